// File: doc/BRIEF.md
# Polled Stereo I2S Master Transceiver

This block drives a stereo audio codec as the I2S bus master. It runs on the codec master clock. From that clock it makes the serial bit clock and the word-select clock. On every stereo frame it shifts one 24-bit sample per channel out to the codec and captures one 24-bit sample per channel from it. The bit clock is a quarter of the master clock. One stereo frame lasts 64 bit clocks, so each channel gets a 32-bit slot. The 24 sample bits sit at the front of the slot, after the usual one-bit delay.

A host reaches the block through a small window of 32-bit registers. There are two receive holding registers, two transmit holding registers and one status register. The host polls the status flag. When the flag is set, it reads the newest left/right pair and then writes the pair to be played next. Transmit values are buffered twice and take effect only at a frame boundary. Receive values are published as one coherent pair once per frame.

Top module: `i2s_xcvr`

## Requirements
- R1: While `rst_n` is low and after its release, `i2s_sck`, `i2s_ws` and `i2s_sd_out` are low, and every register reads as zero until the first receive update.
- R2: `i2s_sck` has a period of 4 `clk` cycles, high for 2 and low for 2, which gives 64 rising edges per frame.
- R3: `i2s_ws` has a period of 64 `i2s_sck` cycles (256 `clk` cycles). It is low for the 32-bit left slot and high for the 32-bit right slot. It changes only when `i2s_sck` falls.
- R4: In each slot, `i2s_sd_out` carries the 24-bit channel sample MSB first, in slot positions 1 to 24, where position 0 is the bit clock that begins with the `i2s_ws` edge. Position 0 and positions 25 to 31 are driven 0. `i2s_sd_out` changes only when `i2s_sck` falls.
- R5: The transmit holding registers are copied into the shifter when a new frame starts, at the falling edge of `i2s_ws`. A write during a frame first appears in the next frame and never splits the sample in flight. The first frame after reset sends zeros.
- R6: `i2s_sd_in` is sampled on rising `i2s_sck` edges. Slot positions 1 to 24 form the channel sample, MSB first. The input at position 0 and at positions 25 to 31 is ignored.
- R7: Both receive registers update together, once per frame, when the 24th bit of the right slot is sampled. Reads return the 24-bit sample sign-extended to 32 bits.
- R8: Status bit 0 is a sticky new-sample flag. A receive update sets it. A read of the receive-right register clears it. An update in the same cycle as that read leaves it set. Reads of other registers do not clear it.
- R9: The registers are at these offsets: receive-left 0x00, receive-right 0x04, transmit-left 0x08, transmit-right 0x0C, status 0x10. Transmit registers read back as written, in the low 24 bits, sign-extended. Writes to 0x00, 0x04 and 0x10 are ignored. Other offsets read as zero. Read data appears in the cycle after the `host_rd` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Codec master clock, which also clocks the whole block |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 5 | Byte offset into the register window |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, registered |
| i2s_sck | output | 1 | Serial bit clock to the codec |
| i2s_ws | output | 1 | Word select, low for the left channel |
| i2s_sd_out | output | 1 | Serial data to the codec |
| i2s_sd_in | input | 1 | Serial data from the codec |

## Verification
The checker assumes that `i2s_sd_in` changes only while `i2s_sck` is low, as a codec driving on the falling edge would. It also assumes that a read of receive-right does not hit the exact update cycle, unless the set-wins rule is what is under test. The bench plays the codec. It changes `i2s_sd_in` only just after it sees a falling bit clock, and it drives ones into the ignored positions. It makes every host access in the middle of the right slot, well away from the frame start and from the receive update. The sample patterns cover walking ones, their complements, full-scale negative and positive values, and arithmetic sequences.

// File: rtl/i2s_xcvr_pkg.sv
// Package: register offsets and bus width shared by the transceiver blocks.
// Assumes byte addressing with 32-bit registers on 4-byte boundaries.
package i2s_xcvr_pkg;
    localparam int          REG_W     = 32;
    localparam int          ADDR_W    = 5;
    localparam logic [4:0]  OFF_RX_L  = 5'h00;
    localparam logic [4:0]  OFF_RX_R  = 5'h04;
    localparam logic [4:0]  OFF_TX_L  = 5'h08;
    localparam logic [4:0]  OFF_TX_R  = 5'h0C;
    localparam logic [4:0]  OFF_STAT  = 5'h10;
endpackage

// File: rtl/i2s_clkgen.sv
// Module: i2s_clkgen
// Divides the master clock into the serial bit clock and the word select.
// Produces one-cycle strobes at the bit-clock fall (launch) and rise (capture).
// Assumes MCLK_PER_SCK is an even power of two (at least 4) and SLOT_W is a
// power of two, so that the counters wrap naturally.
module i2s_clkgen #(
    parameter int MCLK_PER_SCK = 4,
    parameter int SLOT_W       = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic                      sck,
    output logic                      ws,
    output logic [$clog2(SLOT_W)-1:0] slot_pos,
    output logic                      fall_stb,
    output logic                      rise_stb,
    output logic                      frame_stb
);
    localparam int DIV_W   = $clog2(MCLK_PER_SCK);
    localparam int FRAME_W = $clog2(2 * SLOT_W);
    localparam int POS_W   = $clog2(SLOT_W);

    logic [DIV_W-1:0]   div_q;
    logic [FRAME_W-1:0] bit_q;

    assign fall_stb  = (div_q == DIV_W'(MCLK_PER_SCK - 1));
    assign rise_stb  = (div_q == DIV_W'(MCLK_PER_SCK / 2 - 1));
    assign sck       = (div_q >= DIV_W'(MCLK_PER_SCK / 2));
    assign frame_stb = fall_stb && (bit_q == '1);
    assign ws        = bit_q[FRAME_W-1];
    assign slot_pos  = bit_q[POS_W-1:0];

    // Master-clock phase counter inside one bit clock.
    always_ff @(posedge clk) begin
        if (!rst_n)        div_q <= '0;
        else if (fall_stb) div_q <= '0;
        else               div_q <= div_q + 1'b1;
    end

    // Bit position inside the stereo frame, advancing at each bit-clock fall.
    always_ff @(posedge clk) begin
        if (!rst_n)        bit_q <= '0;
        else if (fall_stb) bit_q <= bit_q + 1'b1;
    end
endmodule

// File: rtl/i2s_serializer.sv
// Module: i2s_serializer
// Holds the frame's active left/right samples and selects the bit for the
// current slot position: MSB at position 1, zero elsewhere in the slot.
// Assumes slot_pos and ws change only at the bit-clock fall, so the output
// changes there too.
module i2s_serializer #(
    parameter int SAMPLE_W = 24,
    parameter int SLOT_W   = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_stb,
    input  logic [SAMPLE_W-1:0]       host_l,
    input  logic [SAMPLE_W-1:0]       host_r,
    input  logic                      ws,
    input  logic [$clog2(SLOT_W)-1:0] slot_pos,
    output logic                      sd
);
    localparam int POS_W = $clog2(SLOT_W);

    logic [SAMPLE_W-1:0] act_l;
    logic [SAMPLE_W-1:0] act_r;
    logic [SAMPLE_W-1:0] word;
    logic [POS_W-1:0]    idx;
    logic                in_win;

    // Copy the host samples into the shifter stage at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_l <= '0;
            act_r <= '0;
        end else if (load_stb) begin
            act_l <= host_l;
            act_r <= host_r;
        end
    end

    // Choose the channel and bit for the present slot position.
    always_comb begin
        word   = ws ? act_r : act_l;
        in_win = (slot_pos != '0) && (slot_pos <= POS_W'(SAMPLE_W));
        idx    = POS_W'(SAMPLE_W) - slot_pos;
        sd     = in_win ? word[idx] : 1'b0;
    end
endmodule

// File: rtl/i2s_deserializer.sv
// Module: i2s_deserializer
// Captures serial input at the bit-clock rise in slot positions 1..SAMPLE_W.
// Parks the left sample and publishes both channels as one pair with a
// one-cycle valid pulse when the last right bit arrives.
// Assumes sd_in is stable around the rise strobe.
module i2s_deserializer #(
    parameter int SAMPLE_W = 24,
    parameter int SLOT_W   = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rise_stb,
    input  logic                      ws,
    input  logic [$clog2(SLOT_W)-1:0] slot_pos,
    input  logic                      sd_in,
    output logic [SAMPLE_W-1:0]       rx_l,
    output logic [SAMPLE_W-1:0]       rx_r,
    output logic                      rx_valid
);
    localparam int POS_W = $clog2(SLOT_W);

    logic [SAMPLE_W-1:0] shift_q;
    logic [SAMPLE_W-1:0] shift_nx;
    logic [SAMPLE_W-1:0] park_l;
    logic                in_win;
    logic                last_bit;

    always_comb begin
        shift_nx = {shift_q[SAMPLE_W-2:0], sd_in};
        in_win   = (slot_pos != '0) && (slot_pos <= POS_W'(SAMPLE_W));
        last_bit = rise_stb && (slot_pos == POS_W'(SAMPLE_W));
    end

    // Shift in the sample bits of the current slot.
    always_ff @(posedge clk) begin
        if (!rst_n)                   shift_q <= '0;
        else if (rise_stb && in_win)  shift_q <= shift_nx;
    end

    // Park the completed left sample until the right one finishes.
    always_ff @(posedge clk) begin
        if (!rst_n)                park_l <= '0;
        else if (last_bit && !ws)  park_l <= shift_nx;
    end

    // Publish the pair once per frame, after the right channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_l     <= '0;
            rx_r     <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= last_bit && ws;
            if (last_bit && ws) begin
                rx_l <= park_l;
                rx_r <= shift_nx;
            end
        end
    end
endmodule

// File: rtl/i2s_regfile.sv
// Module: i2s_regfile
// Polled host register window: receive pair, transmit pair and status.
// Handles sign extension on reads and the sticky new-sample flag.
// Assumes single-cycle strobes and that a write and a read do not overlap.
module i2s_regfile
    import i2s_xcvr_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [REG_W-1:0]    host_wdata,
    output logic [REG_W-1:0]    host_rdata,
    input  logic [SAMPLE_W-1:0] rx_l,
    input  logic [SAMPLE_W-1:0] rx_r,
    input  logic                rx_valid,
    output logic [SAMPLE_W-1:0] tx_l,
    output logic [SAMPLE_W-1:0] tx_r,
    output logic                new_flag
);
    localparam int EXT_W = REG_W - SAMPLE_W;

    logic [REG_W-1:0] rd_mux;

    // Host-side transmit holding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_l <= '0;
            tx_r <= '0;
        end else if (host_wr) begin
            if (host_addr == OFF_TX_L) tx_l <= host_wdata[SAMPLE_W-1:0];
            if (host_addr == OFF_TX_R) tx_r <= host_wdata[SAMPLE_W-1:0];
        end
    end

    // Sticky new-sample flag; a fresh update wins over the clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   new_flag <= 1'b0;
        else if (rx_valid)                            new_flag <= 1'b1;
        else if (host_rd && host_addr == OFF_RX_R)    new_flag <= 1'b0;
    end

    // Read-data selection with sign extension of the samples.
    always_comb begin
        case (host_addr)
            OFF_RX_L: rd_mux = {{EXT_W{rx_l[SAMPLE_W-1]}}, rx_l};
            OFF_RX_R: rd_mux = {{EXT_W{rx_r[SAMPLE_W-1]}}, rx_r};
            OFF_TX_L: rd_mux = {{EXT_W{tx_l[SAMPLE_W-1]}}, tx_l};
            OFF_TX_R: rd_mux = {{EXT_W{tx_r[SAMPLE_W-1]}}, tx_r};
            OFF_STAT: rd_mux = {{(REG_W-1){1'b0}}, new_flag};
            default:  rd_mux = '0;
        endcase
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= '0;
        else if (host_rd) host_rdata <= rd_mux;
    end
endmodule

// File: rtl/i2s_xcvr.sv
// Module: i2s_xcvr
// Top of the polled stereo I2S master: clock generation, transmit shifter,
// receive shifter and the host register window.
// Assumes clk is the codec master clock and i2s_sd_in is driven by the codec
// in step with i2s_sck.
module i2s_xcvr
    import i2s_xcvr_pkg::*;
#(
    parameter int MCLK_PER_SCK = 4,
    parameter int SLOT_W       = 32,
    parameter int SAMPLE_W     = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [REG_W-1:0]  host_wdata,
    output logic [REG_W-1:0]  host_rdata,
    output logic              i2s_sck,
    output logic              i2s_ws,
    output logic              i2s_sd_out,
    input  logic              i2s_sd_in
);
    localparam int POS_W = $clog2(SLOT_W);

    logic [POS_W-1:0]    slot_pos;
    logic                fall_stb;
    logic                rise_stb;
    logic                frame_stb;
    logic [SAMPLE_W-1:0] tx_left;
    logic [SAMPLE_W-1:0] tx_right;
    logic [SAMPLE_W-1:0] rx_left;
    logic [SAMPLE_W-1:0] rx_right;
    logic                rx_valid;
    logic                new_flag;

    i2s_clkgen #(.MCLK_PER_SCK(MCLK_PER_SCK), .SLOT_W(SLOT_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .sck(i2s_sck), .ws(i2s_ws),
        .slot_pos(slot_pos), .fall_stb(fall_stb), .rise_stb(rise_stb),
        .frame_stb(frame_stb)
    );

    i2s_serializer #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .load_stb(frame_stb),
        .host_l(tx_left), .host_r(tx_right), .ws(i2s_ws),
        .slot_pos(slot_pos), .sd(i2s_sd_out)
    );

    i2s_deserializer #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_des (
        .clk(clk), .rst_n(rst_n), .rise_stb(rise_stb), .ws(i2s_ws),
        .slot_pos(slot_pos), .sd_in(i2s_sd_in),
        .rx_l(rx_left), .rx_r(rx_right), .rx_valid(rx_valid)
    );

    i2s_regfile #(.SAMPLE_W(SAMPLE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rx_l(rx_left), .rx_r(rx_right), .rx_valid(rx_valid),
        .tx_l(tx_left), .tx_r(tx_right), .new_flag(new_flag)
    );
endmodule

// File: rtl/i2s_xcvr_chk.sv
// Module: i2s_xcvr_chk
// Temporal checks on the serial pins and the receive/status handshake.
// Bound to i2s_xcvr below.
module i2s_xcvr_chk
    import i2s_xcvr_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic                i2s_sck,
    input logic                i2s_ws,
    input logic                i2s_sd_out,
    input logic                host_rd,
    input logic [ADDR_W-1:0]   host_addr,
    input logic                rx_valid,
    input logic                new_flag,
    input logic [SAMPLE_W-1:0] rx_left
);
    // R2
    sck_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(i2s_sck) |=> i2s_sck);
    // R2
    sck_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(i2s_sck) |=> !i2s_sck);
    // R3
    ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(i2s_ws) |-> $fell(i2s_sck));
    // R4
    sd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(i2s_sd_out) |-> $fell(i2s_sck));
    // R7
    update_in_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (i2s_ws && i2s_sck));
    // R7
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_left));
    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> new_flag);
    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == OFF_RX_R && !rx_valid) |=> !new_flag);
endmodule

bind i2s_xcvr i2s_xcvr_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .i2s_sck(i2s_sck), .i2s_ws(i2s_ws),
    .i2s_sd_out(i2s_sd_out), .host_rd(host_rd), .host_addr(host_addr),
    .rx_valid(rx_valid), .new_flag(new_flag), .rx_left(rx_left)
);

// File: tb/tb_i2s_xcvr.sv
// Bench: acts as the host and as the codec, with expected values computed
// arithmetically from the frame index.
module tb_i2s_xcvr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        i2s_sck;
    logic        i2s_ws;
    logic        i2s_sd_out;
    logic        i2s_sd_in = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    logic [23:0] sh_l = '0;
    logic [23:0] sh_r = '0;

    i2s_xcvr dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .i2s_sck(i2s_sck), .i2s_ws(i2s_ws), .i2s_sd_out(i2s_sd_out),
        .i2s_sd_in(i2s_sd_in)
    );

    always #4 clk = ~clk;

    function automatic logic [23:0] rx_pat_l(int k);
        return (24'h1 << (k % 24)) ^ 24'(k * 37);
    endfunction
    function automatic logic [23:0] rx_pat_r(int k);
        return ~rx_pat_l(k);
    endfunction
    function automatic logic [23:0] tx_pat_l(int k);
        return 24'(k * 24'h05A5A3) ^ 24'h800000;
    endfunction
    function automatic logic [23:0] tx_pat_r(int k);
        return 24'(32'h00FF_FFFF >> (k % 24)) ^ 24'(k * 11);
    endfunction
    function automatic logic [31:0] sext(logic [23:0] v);
        return {{8{v[23]}}, v};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    // Codec model: drives i2s_sd_in and decodes i2s_sd_out.
    initial begin
        logic sck_p, ws_p;
        int pos, fidx, cyc, rises;
        logic [23:0] cur_l, cur_r, dec, dec_l, act_l, act_r, w;
        logic pad_bad;
        sck_p = 1'b0; ws_p = 1'b0; pos = 0; fidx = 0; cyc = 0; rises = 0;
        cur_l = rx_pat_l(0); cur_r = rx_pat_r(0);
        dec = '0; dec_l = '0; act_l = '0; act_r = '0; pad_bad = 1'b0;
        wait (rst_n);
        forever begin
            @(negedge clk);
            cyc++;
            if (i2s_sck && !sck_p) begin
                rises++;
                if (pos >= 1 && pos <= 24) dec = {dec[22:0], i2s_sd_out};
                else if (i2s_sd_out) pad_bad = 1'b1;
                if (pos == 24) begin
                    if (!i2s_ws) dec_l = dec;
                    else begin
                        // R4 R5: frame content matches values latched at frame start
                        check(dec_l == act_l, "R5 left word", {8'h0, dec_l}, {8'h0, act_l});
                        check(dec == act_r, "R5 right word", {8'h0, dec}, {8'h0, act_r});
                    end
                end
            end
            if (!i2s_sck && sck_p) begin
                if (i2s_ws != ws_p) pos = 0; else pos++;
                if (ws_p && !i2s_ws) begin
                    if (fidx > 0) begin
                        check(cyc == 256, "R3 frame length", cyc, 256);
                        check(rises == 64, "R2 sck rises per frame", rises, 64);
                    end
                    check(!pad_bad, "R4 padding zero", {31'h0, pad_bad}, 0);
                    fidx++;
                    cur_l = rx_pat_l(fidx); cur_r = rx_pat_r(fidx);
                    act_l = sh_l; act_r = sh_r;
                    cyc = 0; rises = 0; pad_bad = 1'b0;
                end
                w = i2s_ws ? cur_r : cur_l;
                // R6: ones in ignored positions
                i2s_sd_in = (pos >= 1 && pos <= 24) ? w[24 - pos] : 1'b1;
                ws_p = i2s_ws;
            end
            sck_p = i2s_sck;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Host sequence.
    initial begin
        logic [31:0] d;
        repeat (5) @(negedge clk);
        check(!i2s_sck && !i2s_ws && !i2s_sd_out, "R1 pins in reset",
              {29'h0, i2s_sck, i2s_ws, i2s_sd_out}, 0);
        rst_n = 1'b1;
        reg_rd(5'h00, d); check(d == 0, "R1 rx left", d, 0);
        reg_rd(5'h04, d); check(d == 0, "R1 rx right", d, 0);
        reg_rd(5'h08, d); check(d == 0, "R1 tx left", d, 0);
        reg_rd(5'h0C, d); check(d == 0, "R1 tx right", d, 0);
        reg_rd(5'h10, d); check(d == 0, "R1 status", d, 0);
        reg_rd(5'h14, d); check(d == 0, "R9 unmapped", d, 0);
        reg_wr(5'h00, 32'hFFFF_FFFF);
        reg_rd(5'h00, d); check(d == 0, "R9 rx write ignored", d, 0);
        reg_wr(5'h10, 32'h1);
        reg_rd(5'h10, d); check(d == 0, "R9 status write ignored", d, 0);
        for (int k = 0; k < 30; k++) begin
            @(posedge i2s_ws);
            if (k == 0) begin
                reg_rd(5'h10, d); check(d == 0, "R8 no flag before update", d, 0);
            end else if (k != 10) begin
                reg_rd(5'h10, d); check(d == 1, "R8 flag set", d, 1);
                reg_rd(5'h10, d); check(d == 1, "R8 status read keeps flag", d, 1);
                reg_rd(5'h00, d); check(d == sext(rx_pat_l(k-1)), "R7 rx left", d, sext(rx_pat_l(k-1)));
                reg_rd(5'h10, d); check(d == 1, "R8 left read keeps flag", d, 1);
                reg_rd(5'h04, d); check(d == sext(rx_pat_r(k-1)), "R7 rx right", d, sext(rx_pat_r(k-1)));
                reg_rd(5'h10, d); check(d == 0, "R8 right read clears", d, 0);
            end
            // R5: written in the right slot, expected in the next frame
            reg_wr(5'h08, {8'hA5, tx_pat_l(k+1)});
            reg_wr(5'h0C, {8'h3C, tx_pat_r(k+1)});
            sh_l = tx_pat_l(k+1); sh_r = tx_pat_r(k+1);
            reg_rd(5'h08, d); check(d == sext(tx_pat_l(k+1)), "R9 tx left readback", d, sext(tx_pat_l(k+1)));
            reg_rd(5'h0C, d); check(d == sext(tx_pat_r(k+1)), "R9 tx right readback", d, sext(tx_pat_r(k+1)));
        end
        @(negedge i2s_ws);
        @(negedge i2s_ws);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule